// File: doc/BRIEF.md
# VLAN Tag Extractor and Rewriter

This block sits in a byte-wide frame stream. Each byte carries valid, start-of-frame and end-of-frame markers. The block looks at the four bytes that follow the two 6-byte MAC addresses, offsets 12 to 15 counted from the start-of-frame byte. When offsets 12 and 13 hold the tag protocol value 0x8100, the frame is taken as tagged. The 12-bit VLAN identifier is then taken from the low nibble of offset 14 and all of offset 15. It is reported on a side output together with a tagged flag. The report is valid one cycle after offset 15 is accepted, or one cycle after the end of a frame too short to reach offset 15. It then holds until the next start-of-frame is accepted.

On a forwarding path, the block can also replace the identifier in a tagged frame with a forwarding identifier given on a control input. The priority and drop-eligible nibble is left as it was. The frame keeps its length and its byte order, so later hops switch on the new tag without reading the payload.

The block takes ready/valid handshakes on both sides. It adds exactly one register stage of latency.

Top module: `vlan_tag_rewriter`

## Requirements
- R1: A byte accepted on the input (in_valid and in_ready high at a clock edge) is presented on out_valid/out_data one cycle later, with its sof and eof markers unchanged. Bytes leave in the order they entered, and none is added or dropped.
- R2: While out_valid is high and out_ready is low, out_data, out_sof and out_eof hold steady and in_ready is low. Otherwise in_ready is high.
- R3: A frame is tagged when offset 12 equals 0x81 and offset 13 equals 0x00, with offset 0 being the byte with sof. One cycle after offset 15 is accepted, vid_valid and vid_tagged are 1 and vid_id equals {offset14[3:0], offset15}.
- R4: A frame whose offsets 12 and 13 are anything other than 0x81, 0x00 passes through unmodified. One cycle after offset 15 is accepted, vid_valid is 1, vid_tagged is 0 and vid_id is 0.
- R5: A frame whose eof byte is at an offset below 15 is reported untagged. One cycle after the eof byte is accepted, vid_valid is 1, vid_tagged is 0 and vid_id is 0. Its bytes are not modified.
- R6: For a tagged frame with rewrite_en high when offset 14 is accepted, the output carries {offset14[7:4], fwd_vid[11:8]} at offset 14 and fwd_vid[7:0] at offset 15. Both come from the fwd_vid value sampled when offset 14 is accepted. All other bytes are unchanged, and vid_id still reports the incoming identifier.
- R7: For a tagged frame with rewrite_en low when offset 14 is accepted, every byte passes through unchanged.
- R8: Once vid_valid is 1, vid_valid, vid_tagged and vid_id hold until a start-of-frame byte is accepted. In the cycle after that, all three are 0, unless that byte also ends a frame that is too short, in which case R5 applies.
- R9: A start-of-frame byte restarts offset counting at 0, even in the middle of a frame that has no eof.
- R10: After reset, out_valid, vid_valid, vid_tagged and vid_id are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of its frame |
| in_eof | input | 1 | Input byte is the last of its frame |
| rewrite_en | input | 1 | Replace the identifier of tagged frames |
| fwd_vid | input | 12 | Forwarding identifier to write into the tag |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte, possibly rewritten |
| out_sof | output | 1 | Output byte is the first of its frame |
| out_eof | output | 1 | Output byte is the last of its frame |
| vid_valid | output | 1 | Identifier report is valid |
| vid_tagged | output | 1 | Reported frame carried a tag |
| vid_id | output | 12 | Extracted incoming identifier (0 when untagged) |

## Verification
On every cycle, the assertions check several properties. An output byte is held while stalled. An accepted byte always produces output the next cycle. A tagged report never appears without a valid report, and the report holds until a start-of-frame arrives. A start-of-frame always restarts the offset count. Other behaviours can only be shown by the bench's scenarios against its reference model: tag recognition, near-miss protocol values, identifier substitution and nibble preservation, short frames, frames cut off by a new start-of-frame, and byte order under random backpressure.

// File: rtl/vlan_tag_pkg.sv
// Shared constants for the VLAN tag extractor and rewriter.
// Assumes a byte-wide stream and a 12-bit identifier that spans the low
// nibble of the first tag-control byte and the whole second byte.
package vlan_tag_pkg;
    localparam int BYTE_W      = 8;
    localparam int VID_W       = 12;
    localparam int TAG_POS     = 12;
    localparam logic [15:0] TPID_VALUE = 16'h8100;
endpackage

// File: rtl/vtr_pos_counter.sv
// Offset counter: gives the offset of the byte currently offered, counted
// from the accepted start-of-frame byte, and saturates one past the tag.
// Assumes acc is the input handshake of the same byte.
module vtr_pos_counter #(
    parameter int TAG_POS = 12,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             sof,
    output logic [CNT_W-1:0] idx
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(TAG_POS + 4);

    logic [CNT_W-1:0] cnt_q;

    // offset of the offered byte: a start-of-frame forces zero
    assign idx = sof ? '0 : cnt_q;

    // advance once per accepted byte, stopping past the tag
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (acc)
            cnt_q <= (idx == SAT) ? idx : idx + 1'b1;
    end

    // R9: an accepted start-of-frame makes the next byte offset 1
    assert_sof_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sof) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/vtr_tag_parser.sv
// Tag parser: recognises the tag protocol value at offsets TAG_POS and
// TAG_POS+1, captures the identifier, decides on substitution and keeps the
// per-frame report. Assumes idx comes from vtr_pos_counter for the same byte.
module vtr_tag_parser
    import vlan_tag_pkg::*;
#(
    parameter int          TAG_POS = 12,
    parameter int          VID_W   = 12,
    parameter logic [15:0] TPID    = 16'h8100,
    parameter int          CNT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [CNT_W-1:0]  idx,
    input  logic [BYTE_W-1:0] data,
    input  logic              sof,
    input  logic              eof,
    input  logic              rewrite_en,
    input  logic [VID_W-1:0]  fwd_vid,
    output logic              sub_hi,
    output logic              sub_lo,
    output logic [BYTE_W-1:0] fwd_lo,
    output logic              vid_valid,
    output logic              vid_tagged,
    output logic [VID_W-1:0]  vid_id
);
    localparam int HI_W = VID_W - BYTE_W;
    localparam logic [CNT_W-1:0] P_T0 = CNT_W'(TAG_POS);
    localparam logic [CNT_W-1:0] P_T1 = CNT_W'(TAG_POS + 1);
    localparam logic [CNT_W-1:0] P_C0 = CNT_W'(TAG_POS + 2);
    localparam logic [CNT_W-1:0] P_C1 = CNT_W'(TAG_POS + 3);

    logic            hi_match_q;
    logic            tagged_q;
    logic            rw_q;
    logic [HI_W-1:0] vid_hi_q;
    logic [BYTE_W-1:0] fwd_lo_q;

    // substitution selects for the byte now being loaded
    assign sub_hi = (idx == P_C0) && tagged_q && rewrite_en;
    assign sub_lo = (idx == P_C1) && rw_q;
    assign fwd_lo = fwd_lo_q;

    // tag recognition and capture of identifier and forwarding value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_match_q <= 1'b0;
            tagged_q   <= 1'b0;
            rw_q       <= 1'b0;
            vid_hi_q   <= '0;
            fwd_lo_q   <= '0;
        end else if (acc) begin
            if (sof)
                tagged_q <= 1'b0;
            if (idx == P_T0)
                hi_match_q <= (data == TPID[15:8]);
            if (idx == P_T1)
                tagged_q <= hi_match_q && (data == TPID[7:0]);
            if (idx == P_C0) begin
                rw_q     <= tagged_q && rewrite_en;
                vid_hi_q <= data[HI_W-1:0];
                fwd_lo_q <= fwd_vid[BYTE_W-1:0];
            end
        end
    end

    // per-frame report: cleared by start-of-frame, set at tag end or short eof
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_valid  <= 1'b0;
            vid_tagged <= 1'b0;
            vid_id     <= '0;
        end else if (acc) begin
            if (idx == P_C1) begin
                vid_valid  <= 1'b1;
                vid_tagged <= tagged_q;
                vid_id     <= tagged_q ? {vid_hi_q, data} : '0;
            end else if (eof && (idx < P_C1)) begin
                vid_valid  <= 1'b1;
                vid_tagged <= 1'b0;
                vid_id     <= '0;
            end else if (sof) begin
                vid_valid  <= 1'b0;
                vid_tagged <= 1'b0;
                vid_id     <= '0;
            end
        end
    end

    // R3: a tagged report only appears as part of a valid report
    assert_tag_in_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vid_tagged |-> vid_valid);

    // R8: the report holds until a start-of-frame is accepted
    assert_report_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_valid && !(acc && sof)) |=>
            (vid_valid && $stable(vid_id) && $stable(vid_tagged)));

    // R5: a short frame's end yields an untagged report
    assert_short_untagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && eof && (idx < P_C1)) |=> (vid_valid && !vid_tagged && (vid_id == '0)));
endmodule

// File: rtl/vtr_out_stage.sv
// Output stage: one register slot with ready/valid on both sides. It loads
// the offered byte, with the identifier bits swapped in when the parser
// asks. Assumes VID_W is BYTE_W plus a nibble-or-less high part.
module vtr_out_stage
    import vlan_tag_pkg::*;
#(
    parameter int VID_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              sub_hi,
    input  logic              sub_lo,
    input  logic [VID_W-1:0]  fwd_vid,
    input  logic [BYTE_W-1:0] fwd_lo,
    output logic              acc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof
);
    localparam int HI_W = VID_W - BYTE_W;

    logic [BYTE_W-1:0] new_byte;

    // slot is free when empty or being drained this cycle
    assign in_ready = !out_valid || out_ready;
    assign acc      = in_valid && in_ready;

    // choose the passed-through or substituted byte
    always_comb begin
        new_byte = in_data;
        if (sub_hi)
            new_byte = {in_data[BYTE_W-1:HI_W], fwd_vid[VID_W-1:BYTE_W]};
        else if (sub_lo)
            new_byte = fwd_lo;
    end

    // single pipeline register with hold under stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else if (acc) begin
            out_valid <= 1'b1;
            out_data  <= new_byte;
            out_sof   <= in_sof;
            out_eof   <= in_eof;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R2: a stalled output byte stays put
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

    // R1: an accepted byte is on the output the next cycle
    assert_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/vlan_tag_rewriter.sv
// VLAN tag extractor and rewriter top: ties the offset counter, the tag
// parser and the output stage together. Assumes frames start with a
// start-of-frame byte and that the tag follows the two MAC addresses.
module vlan_tag_rewriter
    import vlan_tag_pkg::*;
#(
    parameter int          VID_W   = vlan_tag_pkg::VID_W,
    parameter int          TAG_POS = vlan_tag_pkg::TAG_POS,
    parameter logic [15:0] TPID    = vlan_tag_pkg::TPID_VALUE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              rewrite_en,
    input  logic [VID_W-1:0]  fwd_vid,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              vid_valid,
    output logic              vid_tagged,
    output logic [VID_W-1:0]  vid_id
);
    localparam int CNT_W = $clog2(TAG_POS + 5);

    logic              acc;
    logic [CNT_W-1:0]  idx;
    logic              sub_hi;
    logic              sub_lo;
    logic [BYTE_W-1:0] fwd_lo;

    vtr_pos_counter #(.TAG_POS(TAG_POS), .CNT_W(CNT_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .acc(acc), .sof(in_sof), .idx(idx)
    );

    vtr_tag_parser #(.TAG_POS(TAG_POS), .VID_W(VID_W), .TPID(TPID), .CNT_W(CNT_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .acc(acc), .idx(idx), .data(in_data),
        .sof(in_sof), .eof(in_eof), .rewrite_en(rewrite_en), .fwd_vid(fwd_vid),
        .sub_hi(sub_hi), .sub_lo(sub_lo), .fwd_lo(fwd_lo),
        .vid_valid(vid_valid), .vid_tagged(vid_tagged), .vid_id(vid_id)
    );

    vtr_out_stage #(.VID_W(VID_W)) u_out (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .sub_hi(sub_hi), .sub_lo(sub_lo), .fwd_vid(fwd_vid), .fwd_lo(fwd_lo),
        .acc(acc), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
    );
endmodule

// File: tb/vlan_tag_rewriter_test.sv
// Bench: drives frames, keeps a behavioural reference of the expected
// output slot and identifier report, and compares them on every clock.
module vlan_tag_rewriter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        rewrite_en = 1'b0;
    logic [11:0] fwd_vid = 12'h000;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_sof;
    logic        out_eof;
    logic        vid_valid;
    logic        vid_tagged;
    logic [11:0] vid_id;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit bp_on = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R1";
    logic [15:0] lfsr = 16'hACE1;
    int cycles = 0;

    // reference model state
    int         m_pos = 0;
    bit         m_hi = 0, m_tag = 0, m_rw = 0;
    logic [7:0] m_flo = 0;
    logic [3:0] m_vhi = 0;
    bit         mv = 0;
    logic [7:0] md = 0;
    bit         msof = 0, meof = 0;
    bit         rv = 0, rt = 0;
    logic [11:0] ro = 0;

    vlan_tag_rewriter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .rewrite_en(rewrite_en), .fwd_vid(fwd_vid), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .vid_valid(vid_valid), .vid_tagged(vid_tagged),
        .vid_id(vid_id)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // random downstream readiness when backpressure is on
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_on ? (lfsr[0] | lfsr[5]) : 1'b1;
    end

    // compare against the model, then step the model over the coming edge
    always @(negedge clk) begin
        if (running) begin
            bit acc;
            int pos;
            logic [7:0] ob;
            check(out_valid == mv, cur_req, "out_valid", out_valid, mv);
            if (mv) begin
                check(out_data == md, cur_req, "out_data", out_data, md);
                check({out_sof, out_eof} == {msof, meof}, "R1", "sof/eof",
                      {out_sof, out_eof}, {msof, meof});
            end
            check(in_ready == (!mv || out_ready), "R2", "in_ready", in_ready, !mv || out_ready);
            check(vid_valid == rv, cur_req, "vid_valid", vid_valid, rv);
            check(vid_tagged == rt, cur_req, "vid_tagged", vid_tagged, rt);
            check(vid_id == ro, cur_req, "vid_id", vid_id, ro);
            acc = in_valid && (!mv || out_ready);
            if (acc) begin
                pos = in_sof ? 0 : m_pos;
                ob = in_data;
                if (in_sof) begin
                    rv = 0; rt = 0; ro = 0; m_tag = 0;
                end
                if (pos == 12) m_hi = (in_data == 8'h81);
                if (pos == 13) m_tag = m_hi && (in_data == 8'h00);
                if (pos == 14) begin
                    if (m_tag && rewrite_en) ob = {in_data[7:4], fwd_vid[11:8]};
                    m_rw = m_tag && rewrite_en;
                    m_flo = fwd_vid[7:0];
                    m_vhi = in_data[3:0];
                end
                if (pos == 15) begin
                    if (m_rw) ob = m_flo;
                    rv = 1; rt = m_tag; ro = m_tag ? {m_vhi, in_data} : 12'h000;
                end else if (in_eof && pos < 15) begin
                    rv = 1; rt = 0; ro = 0;
                end
                m_pos = (pos >= 16) ? 16 : pos + 1;
                mv = 1; md = ob; msof = in_sof; meof = in_eof;
            end else if (out_ready) begin
                mv = 0;
            end
        end
    end

    // drive one frame; tpid and tci go to offsets 12..15
    task automatic send_frame(input int len, input logic [15:0] tpid,
                              input logic [15:0] tci, input bit with_eof,
                              input int gap);
        for (int i = 0; i < len; i++) begin
            bit took;
            in_valid = 1'b1;
            in_sof = (i == 0);
            in_eof = with_eof && (i == len - 1);
            case (i)
                12: in_data = tpid[15:8];
                13: in_data = tpid[7:0];
                14: in_data = tci[15:8];
                15: in_data = tci[7:0];
                default: in_data = (i < 12) ? 8'(i + 1) : 8'(i ^ 8'h5a);
            endcase
            do begin
                @(negedge clk);
                took = in_ready;
                @(posedge clk);
                #1;
            end while (!took);
            if (gap > 0 && (i % 3 == 1)) begin
                in_valid = 1'b0;
                repeat (gap) @(posedge clk);
                #1;
            end
        end
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_eof = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // watchdog: a hung run is a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state seen at the ports
        check(out_valid == 1'b0, "R10", "out_valid", out_valid, 0);
        check(vid_valid == 1'b0, "R10", "vid_valid", vid_valid, 0);
        check(vid_tagged == 1'b0, "R10", "vid_tagged", vid_tagged, 0);
        check(vid_id == 12'h000, "R10", "vid_id", vid_id, 0);
        rst_n = 1'b1;
        running = 1'b1;
        idle(2);

        cur_req = "R3"; rewrite_en = 1'b0;
        send_frame(20, 16'h8100, 16'hA5C3, 1, 0); idle(3);

        cur_req = "R6"; rewrite_en = 1'b1; fwd_vid = 12'h7E2;
        send_frame(22, 16'h8100, 16'hE123, 1, 0); idle(2);

        cur_req = "R7"; rewrite_en = 1'b0; fwd_vid = 12'hFFF;
        send_frame(18, 16'h8100, 16'h3FFF, 1, 0); idle(2);

        cur_req = "R4"; rewrite_en = 1'b1;
        send_frame(20, 16'h0800, 16'h4500, 1, 0); idle(2);
        send_frame(20, 16'h8101, 16'h1234, 1, 0); idle(2);
        send_frame(20, 16'h9100, 16'h1234, 1, 0); idle(2);

        cur_req = "R5";
        send_frame(10, 16'h8100, 16'h0001, 1, 0); idle(2);
        send_frame(15, 16'h8100, 16'h0001, 1, 0); idle(2);
        send_frame(1, 16'h8100, 16'h0001, 1, 0); idle(2);

        cur_req = "R3";
        send_frame(16, 16'h8100, 16'h0ABC, 1, 0); idle(2);

        cur_req = "R9"; fwd_vid = 12'h155;
        send_frame(14, 16'h8100, 16'h0ABC, 0, 0);
        send_frame(20, 16'h8100, 16'h2F0F, 1, 0); idle(2);

        cur_req = "R8";
        send_frame(20, 16'h8100, 16'h6042, 1, 2); idle(10);

        cur_req = "R2"; bp_on = 1'b1;
        for (int k = 0; k < 12; k++) begin
            rewrite_en = k[0];
            fwd_vid = 12'(k * 12'h123);
            send_frame(14 + k, (k % 3 == 2) ? 16'h88A8 : 16'h8100, 16'(k * 16'h1357), 1, k % 2);
            idle(1);
        end
        bp_on = 1'b0;
        idle(6);

        running = 1'b0;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule